// File: doc/BRIEF.md
# Register-Programmed Display Timing Generator

This block is the timing engine for a single display output. Software programs the raster geometry through a small write-only register port, commits it with a flush write, and then starts the engine. While it runs, the block produces horizontal and vertical sync pulses with selectable polarity, a data-enable window, and the pixel word that goes to the panel. That word is the incoming pixel, a fill colour used when the pixel source has no data, or a border colour.

Horizontal timing is described by a line length and a pulse width. Vertical timing is not counted in lines. The frame length, the vsync pulse length and the bounds of the vertical display window are absolute pixel-clock counts, measured from the first clock of the frame. Starting and stopping take effect only on frame boundaries. A frame counter and a line counter can be read at the ports, and each has its own enable bit.

Top module: `disp_tgen`

## Requirements
- R1: While running, a line lasts hper pixel clocks (register 0, bits [15:0]). Lines are aligned to the first clock of every frame. hsync is asserted for the first hpw clocks of each line (register 0, bits [31:16]).
- R2: While running, a frame lasts vper pixel clocks (register 1). vsync is asserted for the first vlen clocks of the frame (register 2).
- R3: Register 9 bit 0 makes hsync active-low and bit 1 makes vsync active-low. After reset both are active-high, so both pins are low. When the engine is idle, each sync pin sits at its inactive level.
- R4: de is high exactly when the frame count f and the line position h satisfy vbeg+skew <= f <= vfin+skew and hbeg <= h <= hfin. vbeg is register 4, vfin is register 5, skew is register 6, hbeg is register 3 bits [15:0] and hfin is register 3 bits [31:16]. de is never high while the engine is idle.
- R5: Inside the window, the pixel output carries pix_in if pix_vld is high, and otherwise the fill colour (register 8, reset 0xFF). Outside the window it carries the border colour (register 7, reset 0).
- R6: Writes to registers 0 to 6 go to shadow copies. They become active only at the first frame start that follows a write to register 12 (flush). Without a flush they have no effect.
- R7: Writing 1 to register 11 bit 0 starts an idle engine. Outputs for frame count 0 appear two clocks after the write edge. Writing 0 lets the current frame finish before tg_active falls, and the outputs go idle one clock after that.
- R8: frame_cnt adds one at each frame start when register 10 bit 0 is set. line_cnt adds one at each line end when register 10 bit 1 is set, and returns to 0 at every frame boundary. Each counter holds its value while its bit is clear.
- R9: After reset, tg_active, de, frame_cnt, line_cnt and the pixel output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 4 | register index |
| cfg_wdata | input | 32 | register write data |
| pix_in | input | CW | pixel from the source |
| pix_vld | input | 1 | pix_in holds valid data this cycle |
| pix_rd | output | 1 | counters are inside the display window (pixel consumed) |
| hsync_o | output | 1 | horizontal sync, polarity applied |
| vsync_o | output | 1 | vertical sync, polarity applied |
| de_o | output | 1 | data enable |
| pix_o | output | CW | selected output pixel |
| tg_active | output | 1 | engine is running a frame |
| frame_cnt | output | CNT_W | frame counter |
| line_cnt | output | CNT_W | line counter within the frame |

## Verification
The main function is exercised with three geometries, compared cycle by cycle over a whole frame against a model built from the formulas.

- The first is a plain 10x6 raster with positive syncs.
- The second uses the same raster with a skew of three clocks, both syncs inverted and the source starved. Against the first, this separates skew handling, per-pin polarity and selection of the fill colour.
- The third is an 8x5 raster with a two-clock hsync and a vsync two lines long. It catches period or width terms that were hard-wired instead of taken from the registers.

Directed runs cover the rest. One changes the shadow registers with no flush, then flushes mid-frame, to show the frame-aligned commit. Others toggle each counter-enable bit separately, and others stop the engine mid-frame to show that a frame is never cut short.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int TG_HW = 16;  // horizontal field width
  localparam int TG_FW = 24;  // frame pixel count width

  typedef enum logic [3:0] {
    A_LINE   = 4'd0,
    A_FLEN   = 4'd1,
    A_VLEN   = 4'd2,
    A_HWIN   = 4'd3,
    A_VBEG   = 4'd4,
    A_VFIN   = 4'd5,
    A_SKEW   = 4'd6,
    A_BORDER = 4'd7,
    A_FILL   = 4'd8,
    A_POL    = 4'd9,
    A_CNTEN  = 4'd10,
    A_RUN    = 4'd11,
    A_FLUSH  = 4'd12
  } tg_addr_e;

  typedef struct packed {
    logic [TG_HW-1:0] hper;
    logic [TG_HW-1:0] hpw;
    logic [TG_HW-1:0] hbeg;
    logic [TG_HW-1:0] hfin;
    logic [TG_FW-1:0] vper;
    logic [TG_FW-1:0] vlen;
    logic [TG_FW-1:0] vbeg;
    logic [TG_FW-1:0] vfin;
    logic [TG_FW-1:0] skew;
  } tg_geom_t;
endpackage

// File: rtl/tg_regs.sv
module tg_regs
  import tg_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  output tg_geom_t      act,
  output logic [CW-1:0] border,
  output logic [CW-1:0] fill,
  output logic [1:0]    pol,
  output logic [1:0]    cnt_en,
  output logic          run_req
);
  localparam int HI = DW / 2;
  localparam logic [CW-1:0] FILL_RST = CW'(8'hFF);

  tg_geom_t shd;
  logic     pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd     <= '0;
      act     <= '0;
      pend    <= 1'b0;
      border  <= '0;
      fill    <= FILL_RST;
      pol     <= 2'b00;
      cnt_en  <= 2'b00;
      run_req <= 1'b0;
    end else begin
      if (load && pend) begin
        act  <= shd;
        pend <= 1'b0;
      end
      if (we) begin
        case (tg_addr_e'(addr))
          A_LINE: begin
            shd.hper <= wdata[TG_HW-1:0];
            shd.hpw  <= wdata[HI +: TG_HW];
          end
          A_FLEN:   shd.vper <= wdata[TG_FW-1:0];
          A_VLEN:   shd.vlen <= wdata[TG_FW-1:0];
          A_HWIN: begin
            shd.hbeg <= wdata[TG_HW-1:0];
            shd.hfin <= wdata[HI +: TG_HW];
          end
          A_VBEG:   shd.vbeg <= wdata[TG_FW-1:0];
          A_VFIN:   shd.vfin <= wdata[TG_FW-1:0];
          A_SKEW:   shd.skew <= wdata[TG_FW-1:0];
          A_BORDER: border   <= wdata[CW-1:0];
          A_FILL:   fill     <= wdata[CW-1:0];
          A_POL:    pol      <= wdata[1:0];
          A_CNTEN:  cnt_en   <= wdata[1:0];
          A_RUN:    run_req  <= wdata[0];
          A_FLUSH:  pend     <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  // R6: the active geometry moves only on a frame start with a flush pending
  p_shadow_commit_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> ($past(load) && $past(pend)));
endmodule

// File: rtl/tg_counters.sv
module tg_counters
  import tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run_req,
  input  logic [TG_HW-1:0] hper,
  input  logic [TG_FW-1:0] vper,
  output logic             run,
  output logic [TG_HW-1:0] hpos,
  output logic [TG_FW-1:0] fpix,
  output logic             start,
  output logic             fend,
  output logic             lwrap
);
  assign fend  = run && (fpix == vper - 1'b1);
  assign start = (!run && run_req) || (fend && run_req);
  assign lwrap = run && !fend && (hpos == hper - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      hpos <= '0;
      fpix <= '0;
    end else if (start) begin
      run  <= 1'b1;
      hpos <= '0;
      fpix <= '0;
    end else if (fend) begin
      run  <= 1'b0;
      hpos <= '0;
      fpix <= '0;
    end else if (run) begin
      fpix <= fpix + 1'b1;
      hpos <= lwrap ? '0 : hpos + 1'b1;
    end
  end

  // R1: line position stays inside the programmed line
  p_hpos_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (run && hper != '0) |-> (hpos < hper));
  // R2: frame count stays inside the programmed frame
  p_frame_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (run && vper != '0) |-> (fpix < vper));
  // R7: the engine only stops at the end of a frame
  p_stop_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(fend));
endmodule

// File: rtl/tg_output.sv
module tg_output
  import tg_pkg::*;
#(
  parameter int CW    = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TG_HW-1:0] hpos,
  input  logic [TG_FW-1:0] fpix,
  input  logic             start,
  input  logic             fend,
  input  logic             lwrap,
  input  tg_geom_t         act,
  input  logic [CW-1:0]    border,
  input  logic [CW-1:0]    fill,
  input  logic [1:0]       pol,
  input  logic [1:0]       cnt_en,
  input  logic [CW-1:0]    pix_in,
  input  logic             pix_vld,
  output logic             pix_rd,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [CW-1:0]    pix_o,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] line_cnt
);
  logic [TG_FW-1:0] vlo, vhi;
  logic             hs_raw, vs_raw, in_win;

  assign vlo    = act.vbeg + act.skew;
  assign vhi    = act.vfin + act.skew;
  assign hs_raw = run && (hpos < act.hpw);
  assign vs_raw = run && (fpix < act.vlen);
  assign in_win = run && (hpos >= act.hbeg) && (hpos <= act.hfin) &&
                  (fpix >= vlo) && (fpix <= vhi);
  assign pix_rd = in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      pix_o   <= '0;
    end else begin
      hsync_o <= hs_raw ^ pol[0];
      vsync_o <= vs_raw ^ pol[1];
      de_o    <= in_win;
      pix_o   <= in_win ? (pix_vld ? pix_in : fill) : border;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      line_cnt  <= '0;
    end else begin
      if (start && cnt_en[0]) frame_cnt <= frame_cnt + 1'b1;
      if (start || fend)               line_cnt <= '0;
      else if (lwrap && cnt_en[1])     line_cnt <= line_cnt + 1'b1;
    end
  end

  // R4: no data enable while the engine is idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> !de_o);
  // R3: idle sync pins rest at their inactive level
  p_sync_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (hsync_o == $past(pol[0]) && vsync_o == $past(pol[1])));
  // R8: line counter cleared at each frame start
  p_line_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> (line_cnt == '0));
  // R8: frame counter only steps by one
  p_frame_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_cnt) |-> (frame_cnt == $past(frame_cnt) + 1'b1));
endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import tg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CW    = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [CW-1:0]    pix_in,
  input  logic             pix_vld,
  output logic             pix_rd,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [CW-1:0]    pix_o,
  output logic             tg_active,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] line_cnt
);
  tg_geom_t         act;
  logic [CW-1:0]    border, fill;
  logic [1:0]       pol, cnt_en;
  logic             run_req, run, start, fend, lwrap;
  logic [TG_HW-1:0] hpos;
  logic [TG_FW-1:0] fpix;

  tg_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(start), .act(act), .border(border), .fill(fill), .pol(pol),
    .cnt_en(cnt_en), .run_req(run_req)
  );

  tg_counters u_cnt (
    .clk(clk), .rst(rst), .run_req(run_req), .hper(act.hper), .vper(act.vper),
    .run(run), .hpos(hpos), .fpix(fpix), .start(start), .fend(fend), .lwrap(lwrap)
  );

  tg_output #(.CW(CW), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .run(run), .hpos(hpos), .fpix(fpix), .start(start),
    .fend(fend), .lwrap(lwrap), .act(act), .border(border), .fill(fill),
    .pol(pol), .cnt_en(cnt_en), .pix_in(pix_in), .pix_vld(pix_vld),
    .pix_rd(pix_rd), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_o(pix_o), .frame_cnt(frame_cnt), .line_cnt(line_cnt)
  );

  assign tg_active = run;
endmodule

// File: tb/test_disp_tgen.sv
`timescale 1ns/1ps
module test_disp_tgen;
  localparam int CW = 24;
  localparam int CNT_W = 16;
  localparam logic [CW-1:0] PIX = 24'hA5C3E1;
  localparam logic [CW-1:0] BORD = 24'h123456;
  // hper, hpw, hbeg, hfin, vper, vlen, vbeg, vfin, skew, pol, vld
  localparam int unsigned VEC [3][11] = '{
    '{10, 1, 3, 8, 60, 10, 20, 49, 0, 0, 1},
    '{10, 1, 3, 8, 60, 10, 20, 49, 3, 3, 0},
    '{ 8, 2, 2, 7, 40, 16, 16, 31, 0, 1, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [CW-1:0] pix_in = PIX;
  logic pix_vld = 1'b1;
  logic pix_rd, hsync_o, vsync_o, de_o, tg_active;
  logic [CW-1:0] pix_o;
  logic [CNT_W-1:0] frame_cnt, line_cnt;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disp_tgen i_disp_tgen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_in(pix_in), .pix_vld(pix_vld), .pix_rd(pix_rd),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o),
    .tg_active(tg_active), .frame_cnt(frame_cnt), .line_cnt(line_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int unsigned d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // stop the engine and check the frame is not cut short (R7)
  task automatic stop_engine(input int vper, input logic [1:0] pol);
    int n;
    wr(11, 0);
    n = 0;
    while (tg_active && n < 3 * vper) begin
      @(negedge clk);
      n++;
    end
    chk(n > 1 && n <= vper, "R7 stop waits for frame end", n, vper);
    @(negedge clk);
    chk(de_o == 1'b0, "R4 de idle after stop", de_o, 0);
    chk(hsync_o == pol[0] && vsync_o == pol[1], "R3 idle sync level", {hsync_o, vsync_o}, {pol[0], pol[1]});
    chk(pix_o == BORD, "R5 border when idle", pix_o, BORD);
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned hper, hpw, hbeg, hfin, vper, vlen, vbeg, vfin, skew, vld;
    logic [1:0] pol;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 / R3 / R5 reset state
    chk(tg_active == 1'b0, "R9 inactive after reset", tg_active, 0);
    chk(de_o == 1'b0, "R9 de low after reset", de_o, 0);
    chk(hsync_o == 1'b0 && vsync_o == 1'b0, "R3 syncs low after reset", {hsync_o, vsync_o}, 0);
    chk(pix_o == '0, "R5 border resets to 0", pix_o, 0);
    chk(frame_cnt == '0 && line_cnt == '0, "R9 counters zero", {frame_cnt, line_cnt}, 0);

    wr(7, BORD);
    wr(10, 3);

    for (int e = 0; e < 3; e++) begin
      hper = VEC[e][0]; hpw = VEC[e][1]; hbeg = VEC[e][2]; hfin = VEC[e][3];
      vper = VEC[e][4]; vlen = VEC[e][5]; vbeg = VEC[e][6]; vfin = VEC[e][7];
      skew = VEC[e][8]; pol = 2'(VEC[e][9]); vld = VEC[e][10];
      wr(0, (hpw << 16) | hper);
      wr(1, vper);
      wr(2, vlen);
      wr(3, (hfin << 16) | hbeg);
      wr(4, vbeg);
      wr(5, vfin);
      wr(6, skew);
      wr(9, pol);
      pix_vld = vld[0];
      wr(12, 0);
      wr(11, 1);
      @(posedge clk);
      for (int k = 0; k < int'(vper); k++) begin
        int unsigned h, ln;
        bit ehs, evs, ede;
        logic [CW-1:0] epx;
        @(posedge clk);
        @(negedge clk);
        h   = k % hper;
        ehs = (h < hpw) ^ pol[0];
        evs = (k < vlen) ^ pol[1];
        ede = (k >= vbeg + skew) && (k <= vfin + skew) && (h >= hbeg) && (h <= hfin);
        epx = ede ? (vld ? PIX : 24'h0000FF) : BORD;
        ln  = ((k + 1) == vper) ? 0 : (k + 1) / hper;
        chk(hsync_o == ehs, "R1 hsync", hsync_o, ehs);
        chk(vsync_o == evs, "R2 vsync", vsync_o, evs);
        chk(de_o == ede, "R4 data enable window", de_o, ede);
        chk(pix_o == epx, "R5 pixel select", pix_o, epx);
        chk(line_cnt == CNT_W'(ln), "R8 line count", line_cnt, ln);
        chk(tg_active == 1'b1, "R7 active during frame", tg_active, 1);
      end
      stop_engine(vper, pol);
    end
    chk(frame_cnt == 16'd6, "R8 frame count after table", frame_cnt, 6);

    // R6: shadow write without flush, then flush mid-frame
    wr(0, (4 << 16) | 8);
    wr(11, 1);
    @(posedge clk);
    for (int k = 0; k < 80; k++) begin
      int unsigned kk, w;
      bit ehs;
      @(posedge clk);
      @(negedge clk);
      kk  = k % 40;
      w   = (k < 40) ? 2 : 4;
      ehs = ((kk % 8) < w) ^ 1'b1;
      chk(hsync_o == ehs, "R6 shadow commit at frame start", hsync_o, ehs);
      if (k == 5) begin
        cfg_we = 1'b1; cfg_addr = 4'd12; cfg_wdata = 0;
      end else if (k == 6) begin
        cfg_we = 1'b0;
      end
    end
    stop_engine(40, 2'b01);
    chk(frame_cnt == 16'd9, "R8 frame count after shadow test", frame_cnt, 9);

    // R8: frame counting only
    wr(10, 1);
    wr(11, 1);
    @(posedge clk);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(line_cnt == '0, "R8 line held with bit1 clear", line_cnt, 0);
    chk(frame_cnt == 16'd10, "R8 frame counts with bit0 set", frame_cnt, 10);
    stop_engine(40, 2'b01);

    // R8: line counting only
    wr(10, 2);
    wr(11, 1);
    @(posedge clk);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(line_cnt == 16'd2, "R8 line counts with bit1 set", line_cnt, 2);
    chk(frame_cnt == 16'd10, "R8 frame held with bit0 clear", frame_cnt, 10);
    stop_engine(40, 2'b01);

    finish_run();
  end
endmodule